// File: doc/BRIEF.md
# Low-Side Driver Diagnostic Status Generator

This block turns per-channel sense information from an eight-channel low-side driver into the status byte that the serial interface loads when a read begins. Each channel supplies a comparator flag, high when its output voltage sits above the diagnostic threshold, and its present drive state (on or off). The block returns one status bit per channel.

The channels fall into two groups. In the direct group (channels 3 to 8), the status bit simply follows the synchronised comparator flag. In the filtered group (channels 1 and 2), the bit is high while the channel is healthy. A healthy channel is either off with its output pulled above threshold, or on with its output pulled below threshold. A fault is the opposite pairing: off and below threshold means an open load or a short to ground, and on and above threshold means a short to supply or an overload. A fault must last for a whole filter window before it is latched. The latch holds the bit low until chip select is low and the fault has gone. A host therefore sees a new fault one read late, and the following read gives the true state.

Comparator flags come from the analog domain and pass through a two-flop synchroniser. The filter window is a count of system clock cycles set by a parameter, about 30 µs by default.

Top module: `diag_status_gen`

## Requirements
- R1: After reset, the status vector reads 1 for channels 1 and 2 (bits 1:0) and 0 for channels 3 to 8 (bits 7:2). Bit i always belongs to channel i+1.
- R2: For channels 3 to 8, the status bit equals that channel's comparator flag as sampled two clock edges earlier.
- R3: For channels 1 and 2, the status bit is high while the channel is off with its flag high, or on with its flag low.
- R4: For channels 1 and 2, a fault (off with flag low, or on with flag high, seen after synchronisation) latches and drives the status bit low only after it has been present on FILT_CYCLES consecutive clock edges. A shorter fault leaves the bit high.
- R5: A latched fault keeps its status bit low while chip select is high, even after the fault condition has gone away.
- R6: A latched fault clears only on a clock edge where chip select is low and no filtered fault is present. While the fault persists, chip select low does not release it.
- R7: The filter count for channels 1 and 2 restarts whenever the fault condition drops for even one cycle. Two short faults separated by a gap never add up to a latch.
- R8: For channels 3 to 8, the drive state has no effect on the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select level, active low |
| cmp_hi | input | 8 | Per-channel flag: output above diagnostic threshold (asynchronous) |
| drv_on | input | 8 | Per-channel drive state, 1 = switched on |
| status | output | 8 | Diagnostic status vector, bit i for channel i+1 |

## Verification
Broken synchroniser state shows up on channels 3 to 8 as a status byte that is one cycle early or late compared with the flags, and it appears within three edges of any flag change. A filter counter that does not restart, or that ends one count off, turns a sub-window fault into a low status bit, or delays a real one, on exactly the edge where the window closes. A fault latch that clears without chip select, or with the fault still present, makes bits 1:0 rise back on the first edge after the fault goes away, rather than waiting for the read window. The reference model checks every cycle, so each of these errors is reported on the cycle it happens.

// File: rtl/diag_status_gen.sv
module diag_status_gen #(
  parameter int NCH         = 8,
  parameter int NFILT       = 2,
  parameter int FILT_CYCLES = 3000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic [NCH-1:0] cmp_hi,
  input  logic [NCH-1:0] drv_on,
  output logic [NCH-1:0] status
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [NCH-1:0]   s1, s2;
  logic [NFILT-1:0] fault_raw, fault_seen, flt_q;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      warm <= '0;
    end else begin
      s1   <= cmp_hi;
      s2   <= s1;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end

  assign fault_raw = drv_on[NFILT-1:0] ~^ s2[NFILT-1:0];

  for (genvar j = 0; j < NFILT; j++) begin : g_filt
    logic [CW-1:0] cnt;
    assign fault_seen[j] = fault_raw[j] && (cnt >= LAST);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt      <= '0;
        flt_q[j] <= 1'b0;
      end else begin
        if (!fault_raw[j])  cnt <= '0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
        if (fault_seen[j])  flt_q[j] <= 1'b1;
        else if (!cs_n)     flt_q[j] <= 1'b0;
      end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !status[j]) |=> !status[j]);
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[j]) |-> $past(!cs_n) && !$past(fault_seen[j]));
    p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[j]) |-> $past(fault_raw[j]));
  end

  assign status = {s2[NCH-1:NFILT], ~flt_q};

  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> status[NCH-1:NFILT] == $past(cmp_hi[NCH-1:NFILT], 2));
  p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(status));
endmodule

// File: tb/sim_diag_status_gen.sv
module sim_diag_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 20;
  localparam int NCH = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [NCH-1:0] cmp_hi = 8'hFF, drv_on = 8'h00;
  logic [NCH-1:0] status;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";

  bit [7:0] hist[$];
  int run[2];
  bit lat[2];
  logic [7:0] exp_st;

  diag_status_gen #(.NCH(NCH), .NFILT(2), .FILT_CYCLES(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmp_hi(cmp_hi),
    .drv_on(drv_on), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", req, cycles, act, expv);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hist.delete();
      hist.push_back(8'h00);
      hist.push_back(8'h00);
      run[0] = 0; run[1] = 0; lat[0] = 0; lat[1] = 0;
    end else begin
      bit [7:0] seen;
      seen = hist[0];
      for (int c = 0; c < 2; c++) begin
        bit f, full;
        f = drv_on[c] ? seen[c] : !seen[c];
        full = f && (run[c] >= FILT - 1);
        run[c] = f ? ((run[c] < FILT) ? run[c] + 1 : run[c]) : 0;
        if (full) lat[c] = 1;
        else if (!cs_n) lat[c] = 0;
      end
      void'(hist.pop_front());
      hist.push_back(cmp_hi);
    end
    exp_st = {hist[0][7:2], !lat[1], !lat[0]};
  end

  always @(negedge clk)
    if (rst_n && cycles > 0) check(status === exp_st, phase, status, exp_st);

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    #1 check(status === 8'h03, "R1", status, 8'h03);
    tick(5);
    check(status === 8'hFF, "R2", status, 8'hFF);

    phase = "R2";
    cmp_hi = 8'hA7; tick(3);
    check(status[7:2] === 6'b101001, "R2", status, 8'hA7);
    cmp_hi = 8'h5B; tick(3);
    check(status[7:2] === 6'b010110, "R2", status, 8'h5B);

    phase = "R8";
    drv_on = 8'hFC; tick(3);
    check(status === 8'h5B, "R8", status, 8'h5B);
    drv_on = 8'h54; cmp_hi = 8'hC3; tick(3);
    check(status === 8'hC3, "R8", status, 8'hC3);
    drv_on = 8'h00;

    phase = "R3";
    drv_on[0] = 1'b1; cmp_hi[0] = 1'b0;
    drv_on[1] = 1'b0; cmp_hi[1] = 1'b1;
    tick(2 * FILT);
    check(status[1:0] === 2'b11, "R3", status, {status[7:2], 2'b11});

    phase = "R4";
    cmp_hi[0] = 1'b1; tick(FILT - 1); cmp_hi[0] = 1'b0; tick(6);
    check(status[0] === 1'b1, "R4", status, {status[7:1], 1'b1});
    cmp_hi[0] = 1'b1; tick(FILT + 4);
    check(status[0] === 1'b0, "R4", status, {status[7:1], 1'b0});

    phase = "R5";
    cmp_hi[0] = 1'b0; tick(12);
    check(status[0] === 1'b0, "R5", status, {status[7:1], 1'b0});

    phase = "R6";
    cs_n = 1'b0; tick(2);
    check(status[0] === 1'b1, "R6", status, {status[7:1], 1'b1});
    cs_n = 1'b1;
    cmp_hi[1] = 1'b0; tick(FILT + 4);
    check(status[1] === 1'b0, "R6", status, {status[7:2], 1'b0, status[0]});
    cs_n = 1'b0; tick(6);
    check(status[1] === 1'b0, "R6", status, {status[7:2], 1'b0, status[0]});
    cmp_hi[1] = 1'b1; tick(5);
    check(status[1] === 1'b1, "R6", status, {status[7:2], 1'b1, status[0]});
    cs_n = 1'b1; tick(2);

    phase = "R7";
    drv_on[0] = 1'b0; cmp_hi[0] = 1'b1; tick(4);
    cmp_hi[0] = 1'b0; tick(FILT - 2);
    cmp_hi[0] = 1'b1; tick(1);
    cmp_hi[0] = 1'b0; tick(FILT - 2);
    cmp_hi[0] = 1'b1; tick(6);
    check(status[0] === 1'b1, "R7", status, {status[7:1], 1'b1});

    phase = "R2";
    cmp_hi = 8'h3F; tick(4);
    check(status === 8'h3F, "R2", status, 8'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule